// File: doc/BRIEF.md
# Clock Throttling Pulse Generator

This block throttles a processor by driving a periodic, active-low stop-clock request. Two sources can ask for throttling. A software enable starts normal throttling. An active-low thermal alarm input starts thermal throttling. Each source has its own period select, its own duty setting and its own enable for a companion active-low link-stop output. When the link-stop output is enabled, it is held low for a minimum width at the start of every throttling cycle. That width depends on the period in use.

All timing counts a one-clock microsecond tick, `us_tick`. A cycle is either 244 or 30 ticks long. Within that cycle the stop-clock low time is a fraction of the period, in eighths. Thermal throttling can be delayed by a hold-off of about two seconds. The alarm must stay asserted for the whole hold-off, and the hold-off starts again if the alarm drops. The thermal source wins over the normal source. Every setting is captured at a cycle boundary, so a change made mid-cycle can never produce a shortened pulse.

Top module: `clk_throttle_gen`

## Requirements
- R1: When `norm_long`=1, the period of normal throttling, measured from one falling edge of `stop_clk_n` to the next, is 244 ticks. When `norm_long`=0, the period is 30 ticks.
- R2: Thermal throttling uses `therm_long` to choose its period, 244 ticks or 30 ticks. This choice is independent of the normal setting.
- R3: In each cycle, `stop_clk_n` is low for floor(P x D / 8) ticks, starting at the beginning of the cycle. P is the period in ticks and D is the 3-bit duty value of the active source.
- R4: A duty value of 0 keeps `stop_clk_n` and `link_stop_n` high, even when the source is enabled.
- R5: When the link-stop enable of the active source is 1 and D is not 0, `link_stop_n` goes low together with `stop_clk_n`. It stays low for 16 ticks with the 244-tick period and for 2 ticks with the 30-tick period. When that enable is 0, `link_stop_n` stays high.
- R6: When the thermal source is armed, the thermal period, duty and link-stop settings are used, even if `norm_en` is 1.
- R7: When `therm_hold_en`=1, thermal throttling starts only after `therm_alarm_n` has been low without a break for HOLD_US ticks. If the alarm goes high during the hold-off, the count starts again.
- R8: When `therm_hold_en`=0, thermal throttling begins within 3 ticks after `therm_alarm_n` goes low.
- R9: A change of period or duty takes effect only at the next cycle boundary. `stop_clk_n` falls only in the clock after a tick.
- R10: When `norm_en` goes to 0 and no thermal alarm is present, both outputs are high by the second clock edge.
- R11: While reset is asserted, both outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-clock pulse per microsecond |
| norm_en | input | 1 | Enable for normal throttling |
| norm_long | input | 1 | Normal period select: 1 = 244 ticks, 0 = 30 ticks |
| norm_ls_en | input | 1 | Link-stop enable for normal throttling |
| norm_duty | input | 3 | Low time of normal throttling, in eighths of the period |
| therm_alarm_n | input | 1 | Active-low thermal alarm, asynchronous |
| therm_hold_en | input | 1 | Enable for the thermal hold-off |
| therm_long | input | 1 | Thermal period select: 1 = 244 ticks, 0 = 30 ticks |
| therm_ls_en | input | 1 | Link-stop enable for thermal throttling |
| therm_duty | input | 3 | Low time of thermal throttling, in eighths of the period |
| stop_clk_n | output | 1 | Active-low stop-clock request |
| link_stop_n | output | 1 | Active-low link-stop |

## Verification
The properties assume that `us_tick` is high for one clock at a time and that the thermal alarm passes through the synchronizer, so it takes three clocks to reach the cycle logic. They also assume that while a source stays enabled, only a tick can move the cycle state. The bench keeps within these assumptions. It makes one tick every four clocks and changes all inputs on the falling clock edge. It lets settings settle for more than one full period before it measures, and it keeps each alarm pulse longer than the synchronizer depth.

// File: rtl/clk_thr_pkg.sv
package clk_thr_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_NORM  = 2'd1,
    SRC_THERM = 2'd2
  } thr_src_e;

  localparam int unsigned DUTY_W = 3;
  localparam int unsigned NSRC   = 2;
endpackage

// File: rtl/clk_thr_alarm.sv
module clk_thr_alarm #(
  parameter int unsigned HOLD_US = 2_100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic alarm_n,
  input  logic hold_en,
  output logic armed
);
  localparam int unsigned HW = $clog2(HOLD_US + 1);

  logic          sync1_q, sync2_q;
  logic [HW-1:0] hold_q, hold_d;
  logic          armed_q, armed_d;
  logic          alarm_on;

  // two-flop synchronizer, idle level is high (no alarm)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= alarm_n;
      sync2_q <= sync1_q;
    end
  end

  assign alarm_on = !sync2_q;

  always_comb begin
    hold_d = hold_q;
    if (!alarm_on) begin
      hold_d = '0;
    end else if (tick && (hold_q != HW'(HOLD_US))) begin
      hold_d = hold_q + HW'(1);
    end
    armed_d = alarm_on && (!hold_en || (hold_q == HW'(HOLD_US)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/clk_thr_arb.sv
module clk_thr_arb
  import clk_thr_pkg::*;
#(
  parameter int unsigned LONG_US     = 244,
  parameter int unsigned SHORT_US    = 30,
  parameter int unsigned LONG_LS_US  = 16,
  parameter int unsigned SHORT_LS_US = 2,
  parameter int unsigned PW          = $clog2(LONG_US + 1)
) (
  input  logic              norm_en,
  input  logic              norm_long,
  input  logic              norm_ls_en,
  input  logic [DUTY_W-1:0] norm_duty,
  input  logic              therm_armed,
  input  logic              therm_long,
  input  logic              therm_ls_en,
  input  logic [DUTY_W-1:0] therm_duty,
  output logic              active,
  output logic [PW-1:0]     period,
  output logic [PW-1:0]     low_len,
  output logic [PW-1:0]     ls_len
);
  localparam int unsigned XW = PW + DUTY_W;

  logic              long_s  [NSRC];
  logic              lsen_s  [NSRC];
  logic [DUTY_W-1:0] duty_s  [NSRC];
  logic [PW-1:0]     per_s   [NSRC];
  logic [PW-1:0]     low_s   [NSRC];
  logic [PW-1:0]     ls_s    [NSRC];
  thr_src_e          src;

  assign long_s[0] = norm_long;
  assign lsen_s[0] = norm_ls_en;
  assign duty_s[0] = norm_duty;
  assign long_s[1] = therm_long;
  assign lsen_s[1] = therm_ls_en;
  assign duty_s[1] = therm_duty;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [XW-1:0] prod;
    assign per_s[g] = long_s[g] ? PW'(LONG_US) : PW'(SHORT_US);
    assign prod     = {{DUTY_W{1'b0}}, per_s[g]} * {{PW{1'b0}}, duty_s[g]};
    assign low_s[g] = PW'(prod >> DUTY_W);
    assign ls_s[g]  = (lsen_s[g] && (low_s[g] != '0))
                      ? (long_s[g] ? PW'(LONG_LS_US) : PW'(SHORT_LS_US))
                      : '0;
  end

  always_comb begin
    if (therm_armed)  src = SRC_THERM;
    else if (norm_en) src = SRC_NORM;
    else              src = SRC_IDLE;
  end

  always_comb begin
    active  = (src != SRC_IDLE);
    period  = per_s[0];
    low_len = low_s[0];
    ls_len  = ls_s[0];
    if (src == SRC_THERM) begin
      period  = per_s[1];
      low_len = low_s[1];
      ls_len  = ls_s[1];
    end
  end
endmodule

// File: rtl/clk_thr_cycle.sv
module clk_thr_cycle #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic [PW-1:0] period,
  input  logic [PW-1:0] low_len,
  input  logic [PW-1:0] ls_len,
  output logic          stop_n,
  output logic          ls_n
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] per_q, per_d;
  logic [PW-1:0] low_q, low_d;
  logic [PW-1:0] lsw_q, lsw_d;
  logic          run_q, run_d;
  logic          stop_q, stop_d;
  logic          lsn_q, lsn_d;
  logic          wrap;

  assign wrap = (cnt_q == (per_q - PW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    low_d = low_q;
    lsw_d = lsw_q;
    run_d = run_q;
    if (!active) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (tick) begin
      if (!run_q || wrap) begin
        // cycle boundary: capture the settings for the whole cycle
        run_d = 1'b1;
        cnt_d = '0;
        per_d = period;
        low_d = low_len;
        lsw_d = ls_len;
      end else begin
        cnt_d = cnt_q + PW'(1);
      end
    end
    stop_d = !(run_d && (cnt_d < low_d));
    lsn_d  = !(run_d && (cnt_d < lsw_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      low_q  <= '0;
      lsw_q  <= '0;
      run_q  <= 1'b0;
      stop_q <= 1'b1;
      lsn_q  <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      low_q  <= low_d;
      lsw_q  <= lsw_d;
      run_q  <= run_d;
      stop_q <= stop_d;
      lsn_q  <= lsn_d;
    end
  end

  assign stop_n = stop_q;
  assign ls_n   = lsn_q;
endmodule

// File: rtl/clk_throttle_gen.sv
module clk_throttle_gen #(
  parameter int unsigned LONG_US     = 244,
  parameter int unsigned SHORT_US    = 30,
  parameter int unsigned LONG_LS_US  = 16,
  parameter int unsigned SHORT_LS_US = 2,
  parameter int unsigned HOLD_US     = 2_100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       norm_en,
  input  logic       norm_long,
  input  logic       norm_ls_en,
  input  logic [2:0] norm_duty,
  input  logic       therm_alarm_n,
  input  logic       therm_hold_en,
  input  logic       therm_long,
  input  logic       therm_ls_en,
  input  logic [2:0] therm_duty,
  output logic       stop_clk_n,
  output logic       link_stop_n
);
  localparam int unsigned PW = $clog2(LONG_US + 1);

  logic          rst_s1_q, rst_s2_q;
  logic          therm_armed;
  logic          active;
  logic [PW-1:0] period, low_len, ls_len;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  clk_thr_alarm #(.HOLD_US(HOLD_US)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .tick    (us_tick),
    .alarm_n (therm_alarm_n),
    .hold_en (therm_hold_en),
    .armed   (therm_armed)
  );

  clk_thr_arb #(
    .LONG_US     (LONG_US),
    .SHORT_US    (SHORT_US),
    .LONG_LS_US  (LONG_LS_US),
    .SHORT_LS_US (SHORT_LS_US),
    .PW          (PW)
  ) u_arb (
    .norm_en     (norm_en),
    .norm_long   (norm_long),
    .norm_ls_en  (norm_ls_en),
    .norm_duty   (norm_duty),
    .therm_armed (therm_armed),
    .therm_long  (therm_long),
    .therm_ls_en (therm_ls_en),
    .therm_duty  (therm_duty),
    .active      (active),
    .period      (period),
    .low_len     (low_len),
    .ls_len      (ls_len)
  );

  clk_thr_cycle #(.PW(PW)) u_cycle (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .tick    (us_tick),
    .active  (active),
    .period  (period),
    .low_len (low_len),
    .ls_len  (ls_len),
    .stop_n  (stop_clk_n),
    .ls_n    (link_stop_n)
  );
endmodule

// File: rtl/clk_throttle_chk.sv
module clk_throttle_chk (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic norm_en,
  input logic therm_alarm_n,
  input logic stop_clk_n,
  input logic link_stop_n
);
  logic [1:0] age_q;
  logic       old3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign old3 = (age_q == 2'd3);

  // R10: no source left means both outputs high next clock
  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (old3 && !norm_en && therm_alarm_n && $past(therm_alarm_n)
     && $past(therm_alarm_n, 2) && $past(therm_alarm_n, 3))
    |=> (stop_clk_n && link_stop_n));

  // R9: a stop-clock pulse begins only on a tick
  assert_fall_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) && $fell(stop_clk_n) |-> $past(us_tick));

  // R5: link-stop starts together with stop-clock
  assert_ls_with_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) && $fell(link_stop_n) |-> $fell(stop_clk_n));

  // R3: with a source held enabled, outputs only move after a tick
  assert_stable_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) && $past(norm_en) && !$past(us_tick)
    |-> ($stable(stop_clk_n) && $stable(link_stop_n)));
endmodule

bind clk_throttle_gen clk_throttle_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .us_tick       (us_tick),
  .norm_en       (norm_en),
  .therm_alarm_n (therm_alarm_n),
  .stop_clk_n    (stop_clk_n),
  .link_stop_n   (link_stop_n)
);

// File: tb/clk_throttle_gen_bench.sv
module clk_throttle_gen_bench;
  localparam int TDIV = 4;
  localparam int HOLD = 40;

  typedef struct {
    int    per;
    int    low;
    int    ls;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       us_tick;
  logic       norm_en, norm_long, norm_ls_en;
  logic [2:0] norm_duty;
  logic       therm_alarm_n, therm_hold_en, therm_long, therm_ls_en;
  logic [2:0] therm_duty;
  logic       stop_clk_n, link_stop_n;

  int   errors = 0;
  int   checks = 0;
  int   cyc    = 0;
  bit   mon_on = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_throttle_gen #(.HOLD_US(HOLD)) u_clk_throttle_gen (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .norm_en(norm_en), .norm_long(norm_long), .norm_ls_en(norm_ls_en),
    .norm_duty(norm_duty), .therm_alarm_n(therm_alarm_n),
    .therm_hold_en(therm_hold_en), .therm_long(therm_long),
    .therm_ls_en(therm_ls_en), .therm_duty(therm_duty),
    .stop_clk_n(stop_clk_n), .link_stop_n(link_stop_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generator: one clock high every TDIV clocks
  initial begin
    us_tick = 1'b0;
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  // monitor: measures each full cycle and compares with the queue
  int  fall_cyc, low_cnt, ls_cnt;
  bit  have_prev = 1'b0;
  logic prev_stop = 1'b1;
  always @(negedge clk) begin
    if (!mon_on) begin
      have_prev = 1'b0;
    end else begin
      if (prev_stop && !stop_clk_n) begin
        if (have_prev && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check((cyc - fall_cyc) == e.per * TDIV, {e.tag, " period"}, cyc - fall_cyc, e.per * TDIV);
          check(low_cnt == e.low * TDIV, {e.tag, " low time"}, low_cnt, e.low * TDIV);
          check(ls_cnt == e.ls * TDIV, {e.tag, " link-stop"}, ls_cnt, e.ls * TDIV);
        end
        have_prev = 1'b1;
        fall_cyc  = cyc;
        low_cnt   = 0;
        ls_cnt    = 0;
      end
      if (!stop_clk_n)  low_cnt++;
      if (!link_stop_n) ls_cnt++;
    end
    prev_stop = stop_clk_n;
  end

  task automatic idle_all();
    @(negedge clk);
    norm_en = 1'b0; therm_alarm_n = 1'b1; therm_hold_en = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // driver: configure, settle, then queue expected cycles
  task automatic run_case(input bit nen, input bit nl, input bit nls, input int nd,
                          input bit talarm, input bit tl, input bit tls, input int td,
                          input int per, input int low, input int ls,
                          input string tag, input int n);
    @(negedge clk);
    norm_en = nen; norm_long = nl; norm_ls_en = nls; norm_duty = 3'(nd);
    therm_hold_en = 1'b0; therm_long = tl; therm_ls_en = tls; therm_duty = 3'(td);
    therm_alarm_n = !talarm;
    repeat (1100) @(negedge clk);
    mon_on = 1'b1;
    for (int i = 0; i < n; i++) q.push_back('{per, low, ls, tag});
    wait (q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
    idle_all();
  endtask

  task automatic wait_fall(output int clocks);
    clocks = 0;
    while (stop_clk_n && clocks < 5000) begin
      @(negedge clk);
      clocks++;
    end
  endtask

  initial begin
    int n, lo;
    rst_n = 1'b0;
    norm_en = 1'b0; norm_long = 1'b0; norm_ls_en = 1'b0; norm_duty = 3'd0;
    therm_alarm_n = 1'b1; therm_hold_en = 1'b0; therm_long = 1'b0;
    therm_ls_en = 1'b0; therm_duty = 3'd0;
    repeat (5) @(negedge clk);
    check(stop_clk_n === 1'b1, "R11 stop high in reset", int'(stop_clk_n), 1);
    check(link_stop_n === 1'b1, "R11 link high in reset", int'(link_stop_n), 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R3 R5: normal long period, duty 3, link-stop on
    run_case(1, 1, 1, 3, 0, 0, 0, 0, 244, 91, 16, "R1 R3 R5 normal long", 3);
    // R1 R5: normal short, duty 5, link-stop off
    run_case(1, 0, 0, 5, 0, 0, 0, 0, 30, 18, 0, "R1 R5 normal short", 6);
    // R2 R5: thermal short, duty 7, link-stop on
    run_case(0, 0, 0, 0, 1, 0, 1, 7, 30, 26, 2, "R2 R5 thermal short", 6);
    // R2: thermal long, duty 1
    run_case(0, 1, 1, 0, 1, 1, 0, 1, 244, 30, 0, "R2 thermal long", 2);
    // R6: both active, thermal wins
    run_case(1, 0, 1, 2, 1, 1, 1, 4, 244, 122, 16, "R6 thermal priority", 2);

    // R4: duty 0 keeps outputs high
    @(negedge clk);
    norm_en = 1'b1; norm_long = 1'b0; norm_ls_en = 1'b1; norm_duty = 3'd0;
    n = 0;
    repeat (300 * TDIV) begin
      @(negedge clk);
      if (!stop_clk_n || !link_stop_n) n++;
    end
    check(n == 0, "R4 duty zero no pulses", n, 0);
    idle_all();

    // R9: duty change mid-pulse applies at the next boundary
    @(negedge clk);
    norm_en = 1'b1; norm_long = 1'b0; norm_ls_en = 1'b0; norm_duty = 3'd4;
    wait_fall(n);
    lo = 0;
    while (!stop_clk_n && lo < 1000) begin
      lo++;
      if (lo == 20) norm_duty = 3'd1;
      @(negedge clk);
    end
    check(lo == 15 * TDIV, "R9 current cycle keeps old duty", lo, 15 * TDIV);
    wait_fall(n);
    lo = 0;
    while (!stop_clk_n && lo < 1000) begin
      lo++;
      @(negedge clk);
    end
    check(lo == 3 * TDIV, "R9 next cycle uses new duty", lo, 3 * TDIV);

    // R10: disable in mid-pulse
    wait_fall(n);
    repeat (2) @(negedge clk);
    norm_en = 1'b0;
    repeat (2) @(negedge clk);
    check(stop_clk_n === 1'b1, "R10 stop high after disable", int'(stop_clk_n), 1);
    check(link_stop_n === 1'b1, "R10 link high after disable", int'(link_stop_n), 1);
    idle_all();

    // R8: immediate thermal start
    @(negedge clk);
    therm_hold_en = 1'b0; therm_long = 1'b0; therm_duty = 3'd4; therm_ls_en = 1'b0;
    therm_alarm_n = 1'b0;
    wait_fall(n);
    check(n >= 1 && n <= 3 * TDIV, "R8 immediate start clocks", n, 3 * TDIV);
    idle_all();

    // R7: hold-off before thermal start
    @(negedge clk);
    therm_hold_en = 1'b1;
    therm_alarm_n = 1'b0;
    wait_fall(n);
    check(n >= HOLD * TDIV && n <= (HOLD + 4) * TDIV, "R7 hold-off clocks", n, HOLD * TDIV);
    @(negedge clk);
    therm_alarm_n = 1'b1;
    repeat (20) @(negedge clk);

    // R7: hold-off restarts when the alarm drops
    therm_alarm_n = 1'b0;
    repeat (30 * TDIV) @(negedge clk);
    check(stop_clk_n === 1'b1, "R7 still held off", int'(stop_clk_n), 1);
    therm_alarm_n = 1'b1;
    repeat (4) @(negedge clk);
    therm_alarm_n = 1'b0;
    wait_fall(n);
    check(n >= HOLD * TDIV && n <= (HOLD + 4) * TDIV, "R7 restarted hold-off clocks", n, HOLD * TDIV);
    idle_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule